// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block collects interrupt sources into one output line. Three sub-source banks each hold a 32-bit pending word and a 32-bit mask: an endpoint bank, a DMA bank and a general-purpose bank. Each bank is written through set, clear and mask registers, and a top-level bank of the same shape gathers the bank summaries, line-level core events and a VBUS-change flag. The unmasked top-level pending bits drive one interrupt line. Its active sense is chosen by a control bit.

After a rising edge on the power-on input, a counter holds the line inactive for a programmable number of cycles. The default is 30,000,000 cycles, which is half a second at 60 MHz. Software uses the bus to raise, clear and mask sources and to read back state. Hardware event inputs raise or drop individual top-level bits directly.

Register map (word addresses): address bits 3:2 select the bank, with 0 for top, 1 for endpoint, 2 for DMA and 3 for general-purpose. Address bits 1:0 select the register, with 0 for source, 1 for set, 2 for clear and 3 for mask. Address 0x10 is the control word. Address 0x11 is the read-only status word. Unmapped addresses read as zero.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the top-level mask reads 0xFFFFFFFF, every pending word reads 0, and irq_o is 0.
- R2: A write to a bank's set register ORs the data into its pending word. A write to its clear register clears the bits that are 1 in the data. A write to its mask register replaces the mask. Pending, mask and irq_o reflect the write from the next clock edge.
- R3: Reads of a bank's source, set and clear addresses all return that bank's current pending word. A read of the mask address returns the mask.
- R4: Top-level bit 9 is 1 exactly when an endpoint bit in 15:0 is pending and unmasked. Top-level bit 8 is 1 exactly when an endpoint bit in 31:16 is pending and unmasked.
- R5: Top-level bit 24 is 1 exactly when any DMA bit is pending and unmasked.
- R6: The general-purpose bank stores pending and mask bits, but no top-level bit and no change of irq_o depends on them.
- R7: With control bit 17 at 1, irq_o is high when any top-level bit is pending and unmasked. With it at 0, irq_o is high when no top-level bit is pending and unmasked. In both cases irq_o is 0 while the power gate is closed.
- R8: A rising power_i closes the gate at once. The gate opens PWR_DELAY_CYC cycles after the rising edge, but only if power_i is still 1 then.
- R9: A falling power_i does not change the gate and does not restart the delay. Only a new rising edge closes an open gate again.
- R10: A cycle with evt_valid_i high sets top-level bit evt_id_i when evt_level_i is 1, and clears it when evt_level_i is 0.
- R11: When vbus_i differs from the stored VBUS level, status bit 5 takes the new level and top-level bit 15 is set. An unchanged vbus_i sets nothing.
- R12: Top-level bits 8, 9 and 24 always show the bank summaries. Writing 1s to them through the top set register has no effect on reads or on irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_valid_i | input | 1 | Core event strobe |
| evt_id_i | input | 5 | Top-level bit targeted by the event |
| evt_level_i | input | 1 | Level the targeted bit takes |
| vbus_i | input | 1 | VBUS-valid level |
| power_i | input | 1 | Power-on level |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions check the following on every cycle:
- The set, clear and mask update rules of each bank.
- The gate closing on each power rise and staying open until the next rise.
- The gate opening only with power present.
- irq_o staying low while the gate is closed.
- The VBUS-change flag appearing after a level change.
- The endpoint TX summary dropping after its half is cleared.

The bench scenarios show the rest. These are the summary mapping of both endpoint halves and of the DMA bank, and the isolation of the general-purpose bank. They also cover both polarities, the exact cycle at which the gate opens, and the power drop that aborts the delay. Read-back through the set and clear aliases and the protection of the summary-owned bits are also checked there.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned BANK_TOP  = 0;
  localparam int unsigned BANK_EP   = 1;
  localparam int unsigned BANK_DMA  = 2;
  localparam int unsigned BANK_GPIO = 3;

  typedef enum logic [1:0] {
    REG_SRC = 2'd0,
    REG_SET = 2'd1,
    REG_CLR = 2'd2,
    REG_MSK = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_RX       = 8;
  localparam int unsigned BIT_TX       = 9;
  localparam int unsigned BIT_VBUS_CHG = 15;
  localparam int unsigned BIT_POL      = 17;
  localparam int unsigned BIT_DMA      = 24;
  localparam int unsigned STAT_VBUS    = 5;

  localparam int unsigned OFS_CTRL = 16;
  localparam int unsigned OFS_STAT = 17;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned     W        = 32,
  parameter logic [W-1:0]    MASK_RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic         wr_msk_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  input  logic [W-1:0] hw_clr_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] pend_q, pend_d, mask_q;

  always_comb begin
    pend_d = pend_q;
    if (wr_set_i) pend_d = pend_d | wdata_i;
    if (wr_clr_i) pend_d = pend_d & ~wdata_i;
    // hardware sources win over a same-cycle bus write
    pend_d = (pend_d & ~hw_clr_i) | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      pend_q <= pend_d;
      if (wr_msk_i) mask_q <= wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  p_set_or_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set_i && !(|hw_clr_i)) |=> ((pend_o & $past(wdata_i)) == $past(wdata_i)));
  p_clr_and_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && !wr_set_i && !(|hw_set_i)) |=> ((pend_o & $past(wdata_i)) == '0));
  p_mask_replace_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_msk_i |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/pwr_gate.sv
module pwr_gate #(
  parameter int unsigned DELAY_CYC = 30_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic power_i,
  output logic gate_o
);
  localparam int unsigned CW = $clog2(DELAY_CYC + 1);

  logic          pwr_q, run_q, gate_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = power_i && !pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= 1'b0;
      run_q  <= 1'b0;
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pwr_q <= power_i;
      if (rise) begin
        gate_q <= 1'b0;
        run_q  <= 1'b1;
        cnt_q  <= CW'(DELAY_CYC - 1);
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q <= 1'b0;
          if (power_i) gate_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign gate_o = gate_q;

  p_close_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_i && !pwr_q) |=> !gate_o);
  p_open_needs_power_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(power_i));
  p_hold_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && !(power_i && !pwr_q)) |=> gate_o);
endmodule

// File: rtl/evt_map.sv
module evt_map
  import irq_agg_pkg::*;
#(
  parameter int unsigned W   = DW,
  parameter int unsigned IDW = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           evt_valid_i,
  input  logic [IDW-1:0] evt_id_i,
  input  logic           evt_level_i,
  input  logic           vbus_i,
  output logic [W-1:0]   hw_set_o,
  output logic [W-1:0]   hw_clr_o,
  output logic           vbus_o
);
  logic vbus_q;

  always_comb begin
    hw_set_o = '0;
    hw_clr_o = '0;
    if (evt_valid_i) begin
      if (evt_level_i) hw_set_o[evt_id_i] = 1'b1;
      else             hw_clr_o[evt_id_i] = 1'b1;
    end
    if (vbus_i != vbus_q) hw_set_o[BIT_VBUS_CHG] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vbus_q <= 1'b0;
    else         vbus_q <= vbus_i;
  end

  assign vbus_o = vbus_q;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W        = 6,
  parameter int unsigned PWR_DELAY_CYC = 30_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              evt_valid_i,
  input  logic [4:0]        evt_id_i,
  input  logic              evt_level_i,
  input  logic              vbus_i,
  input  logic              power_i,
  output logic              irq_o
);
  localparam int unsigned HALF = DW / 2;

  logic           in_bank;
  logic [1:0]     bank_sel;
  reg_sel_e       reg_sel;
  logic [DW-1:0]  evt_set, evt_clr;
  logic           vbus_st, gate;
  logic [DW-1:0]  bank_raw  [NUM_BANKS];
  logic [DW-1:0]  bank_mask [NUM_BANKS];
  logic [DW-1:0]  bank_view [NUM_BANKS];
  logic [DW-1:0]  top_eff, ctrl_q, stat_w;
  logic           sum_tx, sum_rx, sum_dma, any_act;

  assign in_bank  = (addr_i[ADDR_W-1:4] == '0);
  assign bank_sel = addr_i[3:2];
  assign reg_sel  = reg_sel_e'(addr_i[1:0]);

  evt_map #(.W(DW), .IDW(5)) u_evt (
    .clk_i, .rst_ni, .evt_valid_i, .evt_id_i, .evt_level_i, .vbus_i,
    .hw_set_o(evt_set), .hw_clr_o(evt_clr), .vbus_o(vbus_st)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = we_i && in_bank && (bank_sel == 2'(b));
    irq_bank #(
      .W       (DW),
      .MASK_RST((b == BANK_TOP) ? {DW{1'b1}} : {DW{1'b0}})
    ) u_bank (
      .clk_i, .rst_ni,
      .wr_set_i(sel && reg_sel == REG_SET),
      .wr_clr_i(sel && reg_sel == REG_CLR),
      .wr_msk_i(sel && reg_sel == REG_MSK),
      .wdata_i,
      .hw_set_i((b == BANK_TOP) ? evt_set : {DW{1'b0}}),
      .hw_clr_i((b == BANK_TOP) ? evt_clr : {DW{1'b0}}),
      .pend_o  (bank_raw[b]),
      .mask_o  (bank_mask[b])
    );
  end

  // bank summaries own their top-level bits
  assign sum_tx  = |(bank_raw[BANK_EP][HALF-1:0]  & ~bank_mask[BANK_EP][HALF-1:0]);
  assign sum_rx  = |(bank_raw[BANK_EP][DW-1:HALF] & ~bank_mask[BANK_EP][DW-1:HALF]);
  assign sum_dma = |(bank_raw[BANK_DMA] & ~bank_mask[BANK_DMA]);

  always_comb begin
    top_eff          = bank_raw[BANK_TOP];
    top_eff[BIT_RX]  = sum_rx;
    top_eff[BIT_TX]  = sum_tx;
    top_eff[BIT_DMA] = sum_dma;
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) bank_view[b] = bank_raw[b];
    bank_view[BANK_TOP] = top_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ctrl_q <= '0;
    else if (we_i && addr_i == ADDR_W'(OFS_CTRL))   ctrl_q <= wdata_i;
  end

  always_comb begin
    stat_w            = '0;
    stat_w[STAT_VBUS] = vbus_st;
  end

  pwr_gate #(.DELAY_CYC(PWR_DELAY_CYC)) u_gate (
    .clk_i, .rst_ni, .power_i, .gate_o(gate)
  );

  assign any_act = |(top_eff & ~bank_mask[BANK_TOP]);
  assign irq_o   = gate && (ctrl_q[BIT_POL] ? any_act : !any_act);

  always_comb begin
    rdata_o = '0;
    if (in_bank) begin
      rdata_o = (reg_sel == REG_MSK) ? bank_mask[bank_sel] : bank_view[bank_sel];
    end else if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rdata_o = ctrl_q;
    end else if (addr_i == ADDR_W'(OFS_STAT)) begin
      rdata_o = stat_w;
    end
  end

  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate |-> !irq_o);
  p_vbus_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbus_i != vbus_st) |=> (top_eff[BIT_VBUS_CHG] && vbus_st == $past(vbus_i)));
  p_tx_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(4 * BANK_EP + 2) && (&wdata_i[HALF-1:0])) |=> !top_eff[BIT_TX]);
endmodule

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;
  localparam int DLY = 20;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        evt_valid_i = 1'b0, evt_level_i = 1'b0, vbus_i = 1'b0, power_i = 1'b0;
  logic [4:0]  evt_id_i = '0;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] m_pend [4];
  logic [31:0] m_mask [4];
  logic [31:0] m_ctrl;
  logic        m_vbus, m_gate;

  always #10 clk_i = ~clk_i;

  irq_agg_top #(.ADDR_W(6), .PWR_DELAY_CYC(DLY)) dut_i (.*);

  function automatic logic [31:0] m_top();
    logic [31:0] t = m_pend[0];
    t[8]  = |(m_pend[1][31:16] & ~m_mask[1][31:16]);
    t[9]  = |(m_pend[1][15:0] & ~m_mask[1][15:0]);
    t[24] = |(m_pend[2] & ~m_mask[2]);
    return t;
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    if (a < 6'h10) begin
      if (a[1:0] == 2'd3) return m_mask[a[3:2]];
      return (a[3:2] == 2'd0) ? m_top() : m_pend[a[3:2]];
    end
    if (a == 6'h10) return m_ctrl;
    if (a == 6'h11) return {26'd0, m_vbus, 5'd0};
    return '0;
  endfunction

  function automatic logic m_irq();
    logic act = |(m_top() & ~m_mask[0]);
    return m_gate && (m_ctrl[17] ? act : !act);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a < 6'h10) begin
      case (a[1:0])
        2'd1: m_pend[a[3:2]] |= d;
        2'd2: m_pend[a[3:2]] &= ~d;
        2'd3: m_mask[a[3:2]] = d;
        default: ;
      endcase
    end else if (a == 6'h10) m_ctrl = d;
  endtask

  task automatic rd_chk(string tag, logic [5:0] a);
    addr_i = a;
    #1;
    chk(tag, rdata_o, m_read(a));
  endtask

  task automatic irq_chk(string tag);
    #1;
    chk(tag, {31'd0, irq_o}, {31'd0, m_irq()});
  endtask

  task automatic evt(logic [4:0] id, logic lvl);
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_id_i = id; evt_level_i = lvl;
    @(negedge clk_i);
    evt_valid_i = 1'b0;
    if (lvl) m_pend[0][id] = 1'b1; else m_pend[0][id] = 1'b0;
  endtask

  task automatic vbus_drive(logic v);
    @(negedge clk_i);
    vbus_i = v;
    @(negedge clk_i);
    if (v != m_vbus) begin
      m_vbus = v;
      m_pend[0][15] = 1'b1;
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < 4; b++) begin m_pend[b] = '0; m_mask[b] = '0; end
    m_mask[0] = '1; m_ctrl = '0; m_vbus = 1'b0; m_gate = 1'b0;

    cycles(3);
    rst_ni = 1'b1;
    cycles(1);
    // R1 reset state
    rd_chk("R1 top mask", 6'h03);
    rd_chk("R1 top pend", 6'h00);
    rd_chk("R1 ep pend", 6'h04);
    irq_chk("R1 irq");

    // R8 exact gate opening; polarity 0 with nothing unmasked -> irq follows gate
    @(negedge clk_i); power_i = 1'b1;
    @(posedge clk_i);
    repeat (DLY - 1) @(posedge clk_i);
    @(negedge clk_i); #1;
    chk("R8 gate closed before delay", {31'd0, irq_o}, 32'd0);
    @(posedge clk_i);
    @(negedge clk_i); #1;
    chk("R8 gate open after delay", {31'd0, irq_o}, 32'd1);
    // R9 power removal keeps gate
    @(negedge clk_i); power_i = 1'b0;
    cycles(DLY + 10); #1;
    chk("R9 gate kept after power off", {31'd0, irq_o}, 32'd1);
    // R9 new rise closes, R8 aborted by early power loss
    power_i = 1'b1;
    cycles(1); #1;
    chk("R9 re-rise closes gate", {31'd0, irq_o}, 32'd0);
    cycles(5); power_i = 1'b0;
    cycles(DLY * 2); #1;
    chk("R8 no open without power", {31'd0, irq_o}, 32'd0);
    power_i = 1'b1;
    cycles(DLY + 5); #1;
    chk("R8 open after full delay", {31'd0, irq_o}, 32'd1);
    m_gate = 1'b1;

    // R7 polarity
    wr(6'h10, 32'h0002_0000);
    irq_chk("R7 pol1 nothing active");
    wr(6'h03, 32'h0000_0000);
    evt(5'd2, 1'b1);
    irq_chk("R7 pol1 active");
    wr(6'h10, 32'h0);
    irq_chk("R7 pol0 active");
    wr(6'h10, 32'h0002_0000);
    rd_chk("R10 event set bit2", 6'h00);
    evt(5'd2, 1'b0);
    rd_chk("R10 event clear bit2", 6'h00);
    irq_chk("R7 pol1 idle again");

    // R4 endpoint halves
    wr(6'h05, 32'h0000_0001);
    rd_chk("R4 tx summary", 6'h00);
    chk("R4 tx bit literal", rdata_o & 32'h300, 32'h200);
    wr(6'h05, 32'h0001_0000);
    rd_chk("R4 rx summary", 6'h00);
    wr(6'h06, 32'h0000_FFFF);
    rd_chk("R4 tx cleared", 6'h00);
    wr(6'h07, 32'hFFFF_0000);
    rd_chk("R4 rx masked", 6'h00);
    irq_chk("R4 irq after mask");
    // R5 DMA
    wr(6'h09, 32'h0000_0004);
    rd_chk("R5 dma summary", 6'h00);
    chk("R5 dma bit literal", rdata_o & 32'h0100_0000, 32'h0100_0000);
    wr(6'h0B, 32'h0000_0004);
    rd_chk("R5 dma masked", 6'h00);
    // R6 gpio isolated
    wr(6'h0D, 32'hFFFF_FFFF);
    wr(6'h0F, 32'h0);
    rd_chk("R6 top unaffected", 6'h00);
    irq_chk("R6 irq unaffected");
    // R3 alias reads
    rd_chk("R3 gpio set alias", 6'h0D);
    rd_chk("R3 gpio clr alias", 6'h0E);
    rd_chk("R3 gpio mask", 6'h0F);
    // R12 summary-owned bits
    wr(6'h01, 32'h0100_0300);
    rd_chk("R12 owned bits unchanged", 6'h00);
    chk("R12 literal", rdata_o & 32'h0100_0300, 32'h0);
    irq_chk("R12 irq");
    // R11 vbus
    vbus_drive(1'b1);
    rd_chk("R11 status", 6'h11);
    rd_chk("R11 change flag", 6'h00);
    wr(6'h02, 32'h0000_8000);
    vbus_drive(1'b1);
    cycles(3);
    rd_chk("R11 no change no flag", 6'h00);
    // R2 mask replace on top
    wr(6'h03, 32'h1234_5678);
    rd_chk("R2 mask replaced", 6'h03);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op <= 5) begin
        logic [5:0] a = {2'b00, 2'($urandom_range(0, 3)), 2'($urandom_range(1, 3))};
        logic [31:0] d = ($urandom_range(0, 1) != 0) ? $urandom() : (32'h1 << $urandom_range(0, 31));
        wr(a, d);
      end else if (op == 6) begin
        wr(6'h10, ($urandom_range(0, 1) != 0) ? 32'h0002_0000 : 32'h0);
      end else if (op <= 8) begin
        evt(5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
      end else begin
        vbus_drive(1'($urandom_range(0, 1)));
      end
      rd_chk("R2 R3 random readback", 6'($urandom_range(0, 17)));
      irq_chk("R7 random irq");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule